// File: doc/BRIEF.md
# Read-Only Serial EEPROM Target (512 bytes)

This block is a target on a two-wire serial bus. It makes a 512-byte store, reached through a synchronous read port, look like a small serial EEPROM that can only be read. The bus master addresses the device with a seven-bit address. The upper four bits of that address are a fixed device tag. The next two bits must equal two strap inputs. The lowest bit does not take part in the match. Instead it becomes the top bit of the nine-bit byte pointer.

A write transfer can only move the pointer. The block accepts one byte carrying the low eight pointer bits and turns away anything after it. A read transfer returns bytes starting at the pointer. It advances the pointer after every byte and wraps at the end of the store, so a master can perform a random read or read the following bytes without resending an address. Bus lines are taken in through synchronisers. The block pulls the data line low through an enable output and never stretches the clock.

Top module: `i2crom_slave`

## Requirements
- R1: After reset the data-line enable and the memory read strobe are both 0, and the byte pointer is 0.
- R2: An address byte is acknowledged only when bits 7..4 equal 1010, bit 3 equals `strap_a2` and bit 2 equals `strap_a1`. Bit 0 is the direction (1 = read). In every other case the address byte is not acknowledged and the block stays silent until the next start.
- R3: Bit 1 of an acknowledged address byte is loaded into pointer bit 8.
- R4: In a write transfer, the first byte after the address is acknowledged and loaded into pointer bits 7..0. A repeated start followed by a read address then returns the byte at that pointer.
- R5: Any further bytes in the same write transfer are not acknowledged and leave the pointer unchanged.
- R6: Read data goes out most significant bit first. The enable changes only while the clock is low, and it is 0 during the master's acknowledge bit.
- R7: The pointer increases by one after each byte sent, and wraps from 511 to 0.
- R8: When the master does not acknowledge a read byte, the block stops driving and ignores further clock pulses until the next start.
- R9: A read address that has no preceding pointer write reads from the current pointer, with bit 8 taken from the address byte.
- R10: A start or stop condition clears the bit count and the transfer state at any point, including in the middle of a byte.
- R11: Each store access is a single-cycle `mem_rd_en` pulse with `mem_addr` equal to the byte about to be sent. `mem_rdata` is taken one cycle later. Exactly one access is made for each byte sent, and none is made for a rejected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_a2 | input | 1 | Device-select strap for address bit 3 |
| strap_a1 | input | 1 | Device-select strap for address bit 2 |
| mem_rd_en | output | 1 | Store read strobe |
| mem_addr | output | 9 | Store byte address |
| mem_rdata | input | 8 | Store read data, valid the cycle after the strobe |

## Verification
A start condition and a rising clock edge can be seen in the same cycle when the master moves both lines in one step. When that happens, the framing logic has to win over the bit shifter. The bench provokes this by breaking off a pointer write after four bits: it raises the clock and drops the data line together, then sends a read address right away. The outcome is judged at the ports. The read address must be acknowledged, and the byte returned must come from the old pointer, proving that the half-received byte was dropped and not taken as a pointer value.

// File: rtl/i2crom_pkg.sv
package i2crom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_EXTRA
  } ph_e;
endpackage

// File: rtl/i2crom_rst_sync.sv
module i2crom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_s = chain_q[1];
endmodule

// File: rtl/i2crom_line.sv
module i2crom_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [1:0] raw;
  logic [1:0] now_v;
  logic [1:0] prev_v;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_wire
    logic [DEPTH-1:0] sr_q;
    logic [DEPTH-1:0] sr_d;

    always_comb sr_d = {sr_q[DEPTH-2:0], raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= sr_d;
    end

    assign now_v[g]  = sr_q[DEPTH-2];
    assign prev_v[g] = sr_q[DEPTH-1];
  end

  assign scl_hi    = now_v[0];
  assign sda_lvl   = now_v[1];
  assign scl_rise  = now_v[0] & ~prev_v[0];
  assign scl_fall  = ~now_v[0] & prev_v[0];
  // framing events use the current clock level so they win over a
  // clock edge seen in the same cycle
  assign start_det = now_v[0] & prev_v[1] & ~now_v[1];
  assign stop_det  = now_v[0] & ~prev_v[1] & now_v[1];
endmodule

// File: rtl/i2crom_ptr.sv
module i2crom_ptr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hi,
  input  logic          hi_val,
  input  logic          ld_lo,
  input  logic [AW-2:0] lo_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ld_hi) ptr_d[AW-1]   = hi_val;
    if (ld_lo) ptr_d[AW-2:0] = lo_val;
    if (inc)   ptr_d         = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R7: one step per sent byte, wrapping at the top of the store
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_hi && !ld_lo) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (ptr_q == '1)) |=> (ptr_q == '0));
endmodule

// File: rtl/i2crom_ctrl.sv
module i2crom_ctrl
  import i2crom_pkg::*;
#(
  parameter logic [3:0] DEV_TAG = 4'b1010,
  parameter int         AW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_hi,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          strap_a2,
  input  logic          strap_a1,
  input  logic [AW-1:0] ptr,
  input  logic [7:0]    mem_rdata,
  output logic          sda_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  output logic          ptr_ld_hi,
  output logic          ptr_hi_val,
  output logic          ptr_ld_lo,
  output logic [AW-2:0] ptr_lo_val,
  output logic          ptr_inc
);
  st_e        st_q, st_d;
  ph_e        ph_q, ph_d;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] buf_q, buf_d;
  logic       full_q, full_d;
  logic       ack_q, ack_d;
  logic       rd_q, rd_d;
  logic       mack_q, mack_d;
  logic       oe_q, oe_d;
  logic       fetch_q;
  logic       rden_q, rden_d;
  logic [AW-1:0] addr_q;
  logic [7:0] byte_w;
  logic       match;

  assign byte_w = {sh_q[6:0], sda_lvl};
  assign match  = (byte_w[7:4] == DEV_TAG) && (byte_w[3] == strap_a2) &&
                  (byte_w[2] == strap_a1);

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    full_d     = full_q;
    ack_d      = ack_q;
    rd_d       = rd_q;
    mack_d     = mack_q;
    rden_d     = 1'b0;
    buf_d      = fetch_q ? mem_rdata : buf_q;
    ptr_ld_hi  = 1'b0;
    ptr_hi_val = byte_w[1];
    ptr_ld_lo  = 1'b0;
    ptr_lo_val = byte_w[AW-2:0];
    ptr_inc    = 1'b0;

    if (stop_det) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_RX;
      ph_d   = PH_DEV;
      cnt_d  = '0;
      full_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = byte_w;
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              full_d = 1'b1;
              unique case (ph_q)
                PH_DEV: begin
                  ack_d     = match;
                  rd_d      = byte_w[0];
                  ptr_ld_hi = match;
                end
                PH_WORD: begin
                  ack_d     = 1'b1;
                  ptr_ld_lo = 1'b1;
                end
                default: ack_d = 1'b0;
              endcase
            end
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            st_d   = ST_ACK;
            rden_d = ack_q && rd_q && (ph_q == PH_DEV);
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (!ack_q) begin
              st_d = ST_IDLE;
            end else if (ph_q == PH_DEV && rd_q) begin
              st_d = ST_TX;
              sh_d = buf_q;
            end else if (ph_q == PH_DEV) begin
              st_d = ST_RX;
              ph_d = PH_WORD;
            end else begin
              st_d = ST_RX;
              ph_d = PH_EXTRA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            sh_d  = {sh_q[6:0], 1'b1};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              st_d    = ST_MACK;
              ptr_inc = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
            rden_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d  = ST_TX;
              sh_d  = buf_q;
              cnt_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end

    unique case (st_d)
      ST_ACK:  oe_d = ack_d;
      ST_TX:   oe_d = ~sh_d[7];
      default: oe_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_DEV;
      cnt_q   <= '0;
      sh_q    <= '1;
      buf_q   <= '1;
      full_q  <= 1'b0;
      ack_q   <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      fetch_q <= 1'b0;
      rden_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      buf_q   <= buf_d;
      full_q  <= full_d;
      ack_q   <= ack_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      fetch_q <= rden_q;
      rden_q  <= rden_d;
      if (rden_d) addr_q <= ptr;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_rd_en = rden_q;
  assign mem_addr  = addr_q;

  // R11: store access is a single-cycle strobe
  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  // R6: output only moves while the clock line is low
  assert_oe_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && scl_hi && !start_det && !stop_det) |=> $stable(sda_oe));
  // R10: framing clears the bit count
  assert_clr_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (cnt_q == 3'd0 && !full_q));
  // R8: master refusal ends the read
  assert_nack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MACK && scl_fall && !mack_q && !start_det && !stop_det)
      |=> (st_q == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2crom_slave.sv
module i2crom_slave #(
  parameter logic [3:0] DEV_TAG     = 4'b1010,
  parameter int         ADDR_W      = 9,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_a2,
  input  logic              strap_a1,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  logic rst_n_s;
  logic scl_hi, scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic ptr_ld_hi, ptr_hi_val, ptr_ld_lo, ptr_inc;
  logic [ADDR_W-2:0] ptr_lo_val;
  logic [ADDR_W-1:0] ptr;

  i2crom_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  i2crom_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2crom_ctrl #(.DEV_TAG(DEV_TAG), .AW(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_hi     (scl_hi),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_lvl    (sda_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_a2   (strap_a2),
    .strap_a1   (strap_a1),
    .ptr        (ptr),
    .mem_rdata  (mem_rdata),
    .sda_oe     (sda_oe),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .ptr_ld_hi  (ptr_ld_hi),
    .ptr_hi_val (ptr_hi_val),
    .ptr_ld_lo  (ptr_ld_lo),
    .ptr_lo_val (ptr_lo_val),
    .ptr_inc    (ptr_inc)
  );

  i2crom_ptr #(.AW(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld_hi  (ptr_ld_hi),
    .hi_val (ptr_hi_val),
    .ld_lo  (ptr_ld_lo),
    .lo_val (ptr_lo_val),
    .inc    (ptr_inc),
    .ptr    (ptr)
  );
endmodule

// File: tb/i2crom_slave_tb.sv
module i2crom_slave_tb;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda;
  logic       sda_oe;
  logic       mem_rd_en;
  logic [8:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  int         total = 0;
  int         bad = 0;
  logic [8:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;
  assign sda = sda_m & ~sda_oe;

  i2crom_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda),
    .sda_oe    (sda_oe),
    .strap_a2  (1'b1),
    .strap_a1  (1'b0),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [8:0] a);
    if (a >= 9'd500) return 8'hFF;
    return (a[7:0] * 8'd13 + 8'd7) ^ (a[8] ? 8'hA5 : 8'h00);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every store access must match the next expected address
  always @(negedge clk) begin
    if (rst_n && mem_rd_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected access", mem_addr, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(mem_addr == e, "R11 access address", mem_addr, e);
      end
    end
  end

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bus_start; sda_m = 1; scl = 1; wq; sda_m = 0; wq; scl = 0; wq; endtask
  task automatic bus_rstart; sda_m = 1; wq; scl = 1; wq; sda_m = 0; wq; scl = 0; wq; endtask
  task automatic bus_stop; sda_m = 0; wq; scl = 1; wq; sda_m = 1; wq; endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq; scl = 1; wq; wq; scl = 0; wq;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wq; scl = 1; wq; ack = (sda == 1'b0); wq; scl = 0; wq;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq; scl = 1; wq; b[i] = sda; wq; scl = 0; wq;
    end
    sda_m = ~mack; wq; scl = 1; wq;
    chk(sda_oe == 1'b0, "R6 released in master ack bit", sda_oe, 0);
    wq; scl = 0; wq; sda_m = 1;
  endtask

  function automatic logic [7:0] dev(input logic a8, input logic rd);
    return {4'b1010, 1'b1, 1'b0, a8, rd};
  endfunction

  task automatic push(input logic [8:0] a, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(a + 9'(k));
  endtask

  task automatic rd_data(input logic [8:0] a, input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      logic [8:0] ak;
      ak = a + 9'(k);
      rbyte(k < n - 1, b);
      chk(b == memf(ak), req, b, memf(ak));
    end
  endtask

  task automatic rand_read(input logic a8, input logic [7:0] w, input int n, input string req);
    logic ack;
    bus_start;
    wbyte(dev(a8, 1'b0), ack); chk(ack, "R2 write address ack", ack, 1);
    wbyte(w, ack);             chk(ack, "R4 pointer byte ack", ack, 1);
    push({a8, w}, n);
    bus_rstart;
    wbyte(dev(a8, 1'b1), ack); chk(ack, "R2 read address ack", ack, 1);
    rd_data({a8, w}, n, req);
    bus_stop;
  endtask

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 enable low in reset", sda_oe, 0);
    chk(mem_rd_en == 1'b0, "R1 strobe low in reset", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0 && mem_rd_en == 1'b0, "R1 quiet after reset", sda_oe, 0);

    // R1 R9: current read from reset pointer
    push(9'h000, 1);
    bus_start;
    wbyte(dev(1'b0, 1'b1), ack); chk(ack, "R2 match ack", ack, 1);
    rd_data(9'h000, 1, "R1 R9 reset pointer read");
    bus_stop;

    // R3 R4 R7: random read with top bit from the address byte
    rand_read(1'b1, 8'h34, 3, "R3 R4 R7 random sequential");

    // R2: wrong strap and wrong tag refused, no access
    bus_start;
    wbyte({4'b1010, 1'b1, 1'b1, 1'b0, 1'b1}, ack);
    chk(!ack, "R2 strap mismatch nack", ack, 0);
    bus_stop;
    bus_start;
    wbyte({4'b1011, 1'b1, 1'b0, 1'b0, 1'b1}, ack);
    chk(!ack, "R2 tag mismatch nack", ack, 0);
    bus_stop;

    // R5: extra write bytes refused and pointer untouched
    bus_start;
    wbyte(dev(1'b0, 1'b0), ack); chk(ack, "R2 write address ack", ack, 1);
    wbyte(8'h10, ack);           chk(ack, "R4 pointer byte ack", ack, 1);
    wbyte(8'h55, ack);           chk(!ack, "R5 extra byte nack", ack, 0);
    bus_stop;
    push(9'h010, 1);
    bus_start;
    wbyte(dev(1'b0, 1'b1), ack); chk(ack, "R2 read address ack", ack, 1);
    rd_data(9'h010, 1, "R5 pointer unchanged by extra byte");
    bus_stop;

    // R7: wrap from 511 to 0, including the all-ones region
    rand_read(1'b1, 8'hFE, 3, "R7 wrap");

    // R9 R8: current read continues, then no drive after master nack
    push(9'h001, 1);
    bus_start;
    wbyte(dev(1'b0, 1'b1), ack); chk(ack, "R2 read address ack", ack, 1);
    rd_data(9'h001, 1, "R9 current pointer read");
    for (int i = 0; i < 9; i++) begin
      sda_m = 1; wq; scl = 1; wq;
      chk(sda == 1'b1 && sda_oe == 1'b0, "R8 silent after nack", sda, 1);
      wq; scl = 0; wq;
    end
    bus_stop;

    // R10: start in the middle of a pointer byte, lines moved together
    bus_start;
    wbyte(dev(1'b1, 1'b0), ack); chk(ack, "R2 write address ack", ack, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    sda_m = 1; wq;
    scl = 1; sda_m = 0; wq;
    scl = 0; wq;
    push(9'h102, 1);
    wbyte(dev(1'b1, 1'b1), ack); chk(ack, "R10 address after abort ack", ack, 1);
    rd_data(9'h102, 1, "R10 partial byte discarded");
    bus_stop;

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all accesses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired (R1..R11 run incomplete)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule